// File: doc/BRIEF.md
# Real-Time Counter Alarm Unit

This block keeps time with a free-running counter that advances once per cycle of a slow timekeeping clock. It compares the count against a programmable alarm value. When the two match and alarms are armed, it raises a one-cycle alarm event. The event can feed a reset, wake-up or interrupt request elsewhere on the chip. Because the event is so short, a sticky capture flag also records it and holds it until software clears it.

Software programs the unit through two write strobes that share one 32-bit data bus. One strobe writes the control bits: alarm enable, auto-reset enable and a write-one-to-clear for the capture flag. The other strobe loads the whole alarm value in one step. The usual way to set an alarm is to disarm, write the new value, then arm again.

When auto-reset is on, the counter restarts from zero after each alarm, so the alarm repeats with a fixed period. When it is off, the counter runs on through the match and wraps modulo 2^CW. A force-load input sets the counter directly, for example to bring it close to the wrap point.

Top module: `rtc_alarm_core`

## Requirements
- R1: While rst_n is low, count, alarm_evt and alarm_seen are zero, and the alarm value and both enables are cleared.
- R2: With no load and no auto-reset pending, count rises by one on every clock and wraps from all ones to zero.
- R3: alarm_evt goes high in the cycle after one in which the alarm enable (control bit 0) is set and count equals the alarm value on all CW bits. It stays low when any bit differs.
- R4: alarm_evt is never high for two cycles in a row.
- R5: With auto-reset (control bit 1) set, count becomes zero on the clock that ends the cycle in which alarm_evt is high, so count reads A, A+1, 0. With auto-reset clear, it reads A, A+1, A+2.
- R6: A control write with bit 0 clear forces alarm_evt low in the next cycle, even when a match is present in the write cycle.
- R7: alarm_seen is set in the cycle after alarm_evt and holds until a control write with bit 2 set clears it. If a set and a clear come in the same cycle, the set wins.
- R8: A write on alm_we replaces the whole alarm value at one clock edge and is used from the next cycle on.
- R9: cnt_ld loads cnt_ld_val into the counter on the next clock. This takes priority over both the auto-reset clear and the increment.
- R10: With auto-reset off, the counter keeps running past a match. Disarming and re-arming without a new alarm value gives no event until the counter wraps around to the alarm value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timekeeping clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe: bit 0 alarm enable, bit 1 auto-reset, bit 2 clear capture flag |
| alm_we | input | 1 | Alarm value write strobe |
| wr_data | input | CW | Write data shared by both strobes |
| cnt_ld | input | 1 | Force-load strobe for the counter |
| cnt_ld_val | input | CW | Value loaded into the counter |
| alarm_evt | output | 1 | One-cycle alarm event |
| alarm_seen | output | 1 | Sticky alarm capture flag |
| count | output | CW | Current counter value |

## Verification
The assertions assume that the strobes and wr_data are synchronous to clk and change only between edges. They also assume that wr_data matters only in a cycle where a strobe is high. The bench changes every input one nanosecond after the rising edge and ties wr_data to the strobe raised in that cycle. The random phase raises at most one write strobe per cycle. Its alarm values are drawn close to the running count, and its loads land close to either zero or the wrap point, so that matches, auto-resets and wraps happen often.

// File: rtl/rtc_alarm_core.sv
module rtc_alarm_core #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          alm_we,
  input  logic [CW-1:0] wr_data,
  input  logic          cnt_ld,
  input  logic [CW-1:0] cnt_ld_val,
  output logic          alarm_evt,
  output logic          alarm_seen,
  output logic [CW-1:0] count
);
  localparam int BIT_EN   = 0;
  localparam int BIT_AUTO = 1;
  localparam int BIT_CLR  = 2;

  logic [CW-1:0] cnt_q, alm_q;
  logic          en_q, auto_q, evt_q, seen_q;
  logic          hit, disarm, clr_seen, wrap_zero;

  assign hit       = en_q && (cnt_q == alm_q);
  assign disarm    = cfg_we && !wr_data[BIT_EN];
  assign clr_seen  = cfg_we && wr_data[BIT_CLR];
  assign wrap_zero = evt_q && auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ld) begin
      cnt_q <= cnt_ld_val;
    end else if (wrap_zero) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alm_q  <= '0;
      en_q   <= 1'b0;
      auto_q <= 1'b0;
    end else begin
      if (alm_we) alm_q <= wr_data;
      if (cfg_we) begin
        en_q   <= wr_data[BIT_EN];
        auto_q <= wr_data[BIT_AUTO];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      evt_q  <= hit && !evt_q && !disarm;
      seen_q <= evt_q || (seen_q && !clr_seen);
    end
  end

  assign alarm_evt  = evt_q;
  assign alarm_seen = seen_q;
  assign count      = cnt_q;

  AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> !alarm_evt); // R4
  AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_evt) |-> $past(en_q && (count == alm_q))); // R3
  AST_DISARM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !wr_data[BIT_EN]) |=> !alarm_evt); // R6
  AST_AUTO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_evt && auto_q && !cnt_ld) |=> (count == '0)); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_ld |=> (count == $past(cnt_ld_val))); // R9
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_ld && !(alarm_evt && auto_q)) |=> (count == $past(count) + 1'b1)); // R2
  AST_SEEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_seen && !(cfg_we && wr_data[BIT_CLR])) |=> alarm_seen); // R7
  AST_SEEN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> alarm_seen); // R7
endmodule

// File: tb/test_rtc_alarm_core.sv
module test_rtc_alarm_core;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0, alm_we = 1'b0, cnt_ld = 1'b0;
  logic [CW-1:0] wr_data = '0, cnt_ld_val = '0;
  logic          alarm_evt, alarm_seen;
  logic [CW-1:0] count;

  int total = 0, bad = 0;
  bit done = 1'b0;

  rtc_alarm_core #(.CW(CW)) i_rtc_alarm_core (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .alm_we(alm_we),
    .wr_data(wr_data), .cnt_ld(cnt_ld), .cnt_ld_val(cnt_ld_val),
    .alarm_evt(alarm_evt), .alarm_seen(alarm_seen), .count(count)
  );

  always #2 clk = ~clk;

  // Reference model built from the requirements
  logic [CW-1:0] m_cnt, m_alm;
  logic          m_en, m_auto, m_evt, m_seen;

  function automatic logic [CW-1:0] f_cnt(logic [CW-1:0] c, logic ld, logic [CW-1:0] lv,
                                          logic ev, logic au);
    if (ld) return lv;
    if (ev && au) return '0;
    return c + 1'b1;
  endfunction

  function automatic logic f_evt(logic en, logic [CW-1:0] c, logic [CW-1:0] a, logic ev,
                                 logic we, logic [CW-1:0] d);
    return en && (c == a) && !ev && !(we && !d[0]);
  endfunction

  function automatic logic f_seen(logic s, logic ev, logic we, logic [CW-1:0] d);
    return ev || (s && !(we && d[2]));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_alm <= '0; m_en <= 1'b0; m_auto <= 1'b0; m_evt <= 1'b0; m_seen <= 1'b0;
    end else begin
      m_cnt  <= f_cnt(m_cnt, cnt_ld, cnt_ld_val, m_evt, m_auto);
      m_evt  <= f_evt(m_en, m_cnt, m_alm, m_evt, cfg_we, wr_data);
      m_seen <= f_seen(m_seen, m_evt, cfg_we, wr_data);
      if (alm_we) m_alm <= wr_data;
      if (cfg_we) begin m_en <= wr_data[0]; m_auto <= wr_data[1]; end
    end
  end

  task automatic chk(string tag, logic [CW-1:0] act, logic [CW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    cfg_we = 1'b0; alm_we = 1'b0; cnt_ld = 1'b0;
  endtask

  task automatic wr_cfg(logic [CW-1:0] d);
    cfg_we = 1'b1; wr_data = d; cyc();
  endtask

  task automatic wr_alm(logic [CW-1:0] d);
    alm_we = 1'b1; wr_data = d; cyc();
  endtask

  task automatic load(logic [CW-1:0] v);
    cnt_ld = 1'b1; cnt_ld_val = v; cyc();
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    #10;
    chk("R1 count", count, 0);
    chk("R1 evt", {31'd0, alarm_evt}, 0);
    chk("R1 seen", {31'd0, alarm_seen}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    cyc(); cyc();
    chk("R2 increment", count, 2);

    load(32'hFFFF_FFFE);
    chk("R9 load", count, 32'hFFFF_FFFE);
    cyc(); chk("R2 max", count, 32'hFFFF_FFFF);
    cyc(); chk("R2 wrap", count, 0);

    wr_alm(10); wr_cfg(1); load(7);
    cyc(); cyc(); cyc();
    chk("R3 lag", {31'd0, alarm_evt}, 0);
    chk("R8 count at alarm", count, 10);
    cyc();
    chk("R3 event", {31'd0, alarm_evt}, 1);
    chk("R5 no auto", count, 11);
    cyc();
    chk("R4 one cycle", {31'd0, alarm_evt}, 0);
    chk("R7 captured", {31'd0, alarm_seen}, 1);
    chk("R5 no auto next", count, 12);
    cyc(); cyc();
    chk("R7 holds", {31'd0, alarm_seen}, 1);
    wr_cfg(32'h5);
    chk("R7 clear", {31'd0, alarm_seen}, 0);

    wr_alm(22); wr_cfg(3); load(20);
    cyc(); cyc();
    chk("R3 lag auto", {31'd0, alarm_evt}, 0);
    cyc();
    chk("R3 event auto", {31'd0, alarm_evt}, 1);
    chk("R5 before clear", count, 23);
    cyc();
    chk("R5 auto zero", count, 0);
    cyc();
    chk("R5 restart", count, 1);

    wr_cfg(32'h7); wr_alm(40); load(38);
    cyc(); cyc(); cyc();
    chk("R3 event 40", {31'd0, alarm_evt}, 1);
    cfg_we = 1'b1; wr_data = 32'h7; cnt_ld = 1'b1; cnt_ld_val = 100;
    cyc();
    chk("R9 load over auto", count, 100);
    chk("R7 set wins", {31'd0, alarm_seen}, 1);

    wr_alm(110); load(108);
    cyc(); cyc();
    chk("R6 at match", count, 110);
    wr_cfg(2);
    chk("R6 disarm", {31'd0, alarm_evt}, 0);
    chk("R6 count", count, 111);
    cyc();
    chk("R6 no clear", count, 112);

    wr_alm(32'h8000_0005); wr_cfg(1); load(3);
    for (int i = 0; i < 6; i++) begin
      cyc();
      chk("R3 partial bits", {31'd0, alarm_evt}, 0);
    end

    wr_alm(2); wr_cfg(1); load(32'hFFFF_FFFD);
    for (int i = 0; i < 5; i++) cyc();
    chk("R10 wrap count", count, 2);
    cyc();
    chk("R10 wrap event", {31'd0, alarm_evt}, 1);
    wr_cfg(0); wr_cfg(1);
    for (int i = 0; i < 20; i++) begin
      cyc();
      chk("R10 no rearm", {31'd0, alarm_evt}, 0);
    end

    for (int n = 0; n < 3000; n++) begin
      int unsigned r;
      r = $urandom % 16;
      if (r == 0) begin
        cfg_we = 1'b1; wr_data = CW'($urandom % 8);
      end else if (r == 1) begin
        alm_we = 1'b1; wr_data = m_cnt + CW'($urandom % 8);
      end else if (r == 2) begin
        cnt_ld = 1'b1;
        cnt_ld_val = ($urandom % 2) ? CW'($urandom % 16) : (32'hFFFF_FFF8 + CW'($urandom % 8));
      end
      cyc();
      chk("R2 model count", count, m_cnt);
      chk("R3 model evt", {31'd0, alarm_evt}, {31'd0, m_evt});
      chk("R7 model seen", {31'd0, alarm_seen}, {31'd0, m_seen});
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule